// File: doc/BRIEF.md
# Keyed Byte-Array Write Controller

This block sits on a small processor register bus and guards a byte-wide nonvolatile data array. Software loads a target address and a data byte into two registers. It then writes a two-byte unlock key to a key register and sets a start bit in the control register, with write-enable set in that same write. Only then does the controller latch the address and data and run a programming cycle of fixed length. At the end of the cycle it stores the byte.

During the cycle the start bit reads back as 1 and the `busy` output is high. Software polls either one to learn when the array is free. When the cycle ends, hardware drops the busy indication and raises a sticky completion flag, which software clears by writing a 1 to it. A separate array read strobe returns the byte at the current address register one clock later. The read is withheld when it targets the location that is being programmed.

The cycle length is a parameter. The default gives a few thousand clocks, a multi-millisecond interval at a few MHz.

Top module: `nvm_write_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `arr_rvalid` and `reg_rdata` are 0, write-enable is 0, and a control register read returns 0x00.
- R2: A start request is honoured only when the two register accesses just before it were writes to the key register (select 3): first 0x55, then 0xAA. A wrong key value or any other register access (read or write) between the key writes and the start cancels the unlock, and the start is then ignored.
- R3: The control write (select 2) that sets start (bit 0) must also carry write-enable (bit 1) = 1 and memory-select (bit 2) = 0. Otherwise no cycle begins.
- R4: An honoured start sets `busy` and control bit 0 on the same clock edge. Both stay 1 for exactly CYCLE_LEN clocks, then clear by themselves.
- R5: At the end of the cycle, the array location given by the address register at start time receives the data register value from start time. Writes to the address (select 0) and data (select 1) registers during the cycle do not change the target or the value.
- R6: During a cycle, a fully unlocked start request is ignored and does not restart the timer. Writing 0 to write-enable or to the start bit neither aborts nor shortens the cycle.
- R7: The completion flag (`done`, control bit 3) is set when a cycle ends and stays set until a control write with bit 3 = 1 clears it. If that clear lands in the same cycle that a cycle ends, the flag ends up set.
- R8: A pulse on `arr_rd` makes `arr_rvalid` 1 and `arr_rdata` equal to the array byte at the address register on the next clock. If a cycle is in progress and the address register equals the latched target, `arr_rvalid` is 0 instead.
- R9: A pulse on `reg_rd` returns the selected register on `reg_rdata` on the next clock. The control layout is bit 0 busy, bit 1 write-enable, bit 2 memory-select, bit 3 done, upper bits 0. The key register reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered register read data |
| arr_rd | input | 1 | Array read strobe at the address register |
| arr_rdata | output | 8 | Array read byte |
| arr_rvalid | output | 1 | Array read returned data (0 when blocked) |
| busy | output | 1 | Programming cycle in progress |
| done | output | 1 | Sticky completion flag |

## Verification
Two functions can meet on one clock edge: the end of a programming cycle, which sets the completion flag, and a software write that clears that flag. The bench counts clocks from the start edge. It places a control write with bit 3 set so that it lands exactly on the edge where busy falls. The flag must read 1 afterwards, and the array must hold the new byte. The bench also overlaps an array read of the busy location with a running cycle and expects the read to be refused. A read of a different location in the same cycle must return data.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
  localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_KEY  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_HALF  = 2'd1,
    UL_ARMED = 2'd2
  } unlock_e;

  localparam int CB_START = 0;
  localparam int CB_WEN   = 1;
  localparam int CB_MSEL  = 2;
  localparam int CB_DONE  = 3;
endpackage

// File: rtl/nvm_unlock.sv
module nvm_unlock
  import nvm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic              key_wr,
  input  logic [BYTE_W-1:0] key_val,
  output logic              armed
);
  unlock_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (acc) begin
      if (key_wr && key_val == KEY_FIRST)
        st_d = UL_HALF;
      else if (st_q == UL_HALF && key_wr && key_val == KEY_SECOND)
        st_d = UL_ARMED;
      else
        st_d = UL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= UL_IDLE;
    else     st_q <= st_d;
  end

  assign armed = (st_q == UL_ARMED);

  AST_ARMED_AFTER_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(key_wr && key_val == KEY_SECOND)); // R2
endmodule

// File: rtl/nvm_prog_timer.sv
module nvm_prog_timer
  import nvm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CYCLE_LEN = 6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [BYTE_W-1:0] in_data,
  output logic              busy,
  output logic              fin,
  output logic [ADDR_W-1:0] lat_addr,
  output logic [BYTE_W-1:0] lat_data
);
  localparam int CNT_W = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_LEN - 1);

  logic [CNT_W-1:0] cnt;

  assign fin = busy && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      lat_addr <= '0;
      lat_data <= '0;
    end else if (busy) begin
      if (fin) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (go) begin
      busy     <= 1'b1;
      cnt      <= '0;
      lat_addr <= in_addr;
      lat_data <= in_data;
    end
  end

  AST_LATCH_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(lat_addr) && $stable(lat_data))); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (int'(cnt) < CYCLE_LEN)); // R4
endmodule

// File: rtl/nvm_array.sv
module nvm_array
  import nvm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [BYTE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/nvm_write_ctrl.sv
module nvm_write_ctrl
  import nvm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CYCLE_LEN = 6000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_sel,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              arr_rd,
  output logic [BYTE_W-1:0] arr_rdata,
  output logic              arr_rvalid,
  output logic              busy,
  output logic              done
);
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;
  logic              wen_q, msel_q;
  logic              armed, fin, go;
  logic [ADDR_W-1:0] lat_addr;
  logic [BYTE_W-1:0] lat_data;
  logic              wr_addr, wr_data, wr_ctrl, wr_key;
  logic [BYTE_W-1:0] ctrl_view;

  assign wr_addr = reg_wr && reg_sel == SEL_ADDR;
  assign wr_data = reg_wr && reg_sel == SEL_DATA;
  assign wr_ctrl = reg_wr && reg_sel == SEL_CTRL;
  assign wr_key  = reg_wr && reg_sel == SEL_KEY;

  assign go = wr_ctrl && reg_wdata[CB_START] && reg_wdata[CB_WEN]
              && !reg_wdata[CB_MSEL] && armed && !busy;

  nvm_unlock u_unlock (
    .clk     (clk),
    .rst     (rst),
    .acc     (reg_wr || reg_rd),
    .key_wr  (wr_key),
    .key_val (reg_wdata),
    .armed   (armed)
  );

  nvm_prog_timer #(.ADDR_W(ADDR_W), .CYCLE_LEN(CYCLE_LEN)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .in_addr  (addr_q),
    .in_data  (data_q),
    .busy     (busy),
    .fin      (fin),
    .lat_addr (lat_addr),
    .lat_data (lat_data)
  );

  nvm_array #(.ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .we    (fin),
    .waddr (lat_addr),
    .wdata (lat_data),
    .re    (arr_rd),
    .raddr (addr_q),
    .rdata (arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
      wen_q  <= 1'b0;
      msel_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      if (wr_addr) addr_q <= reg_wdata[ADDR_W-1:0];
      if (wr_data) data_q <= reg_wdata;
      if (wr_ctrl) begin
        wen_q  <= reg_wdata[CB_WEN];
        msel_q <= reg_wdata[CB_MSEL];
      end
      if (fin)
        done <= 1'b1;
      else if (wr_ctrl && reg_wdata[CB_DONE])
        done <= 1'b0;
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CB_START] = busy;
    ctrl_view[CB_WEN]   = wen_q;
    ctrl_view[CB_MSEL]  = msel_q;
    ctrl_view[CB_DONE]  = done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      arr_rvalid <= 1'b0;
    end else begin
      if (reg_rd) begin
        unique case (reg_sel)
          SEL_ADDR: reg_rdata <= BYTE_W'(addr_q);
          SEL_DATA: reg_rdata <= data_q;
          SEL_CTRL: reg_rdata <= ctrl_view;
          default:  reg_rdata <= '0;
        endcase
      end
      arr_rvalid <= arr_rd && !(busy && addr_q == lat_addr);
    end
  end

  AST_START_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(armed)); // R2
  AST_START_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wdata[CB_WEN] && !reg_wdata[CB_MSEL])); // R3
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done); // R7
  AST_BUSY_READ_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (arr_rd && busy && addr_q == lat_addr) |=> !arr_rvalid); // R8
endmodule

// File: tb/tb_nvm_write_ctrl.sv
module tb_nvm_write_ctrl;
  localparam int CL = 40;

  typedef struct {
    string      tag;
    logic       valid;
    logic [7:0] val;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, arr_rd = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata, arr_rdata;
  logic       arr_rvalid, busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic rd_d = 1'b0, ard_d = 1'b0;
  exp_t reg_q[$];
  exp_t arr_q[$];

  always #5 clk = ~clk;

  nvm_write_ctrl #(.ADDR_W(8), .CYCLE_LEN(CL)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .arr_rd(arr_rd), .arr_rdata(arr_rdata), .arr_rvalid(arr_rvalid),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc   <= cyc + 1;
    rd_d  <= reg_rd;
    ard_d <= arr_rd;
  end

  // monitor: pops expected items and compares
  always @(negedge clk) begin
    if (rd_d) begin
      exp_t e;
      e = reg_q.pop_front();
      checks++;
      if (reg_rdata !== e.val) begin
        errors++;
        $display("FAIL %s reg_rdata actual=%h expected=%h", e.tag, reg_rdata, e.val);
      end
    end
    if (ard_d) begin
      exp_t e;
      e = arr_q.pop_front();
      checks++;
      if (arr_rvalid !== e.valid || (e.valid && arr_rdata !== e.val)) begin
        errors++;
        $display("FAIL %s arr valid/data actual=%b/%h expected=%b/%h",
                 e.tag, arr_rvalid, arr_rdata, e.valid, e.val);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [7:0] exp, input string tag);
    exp_t e;
    e.tag = tag; e.valid = 1'b1; e.val = exp;
    reg_q.push_back(e);
    reg_rd = 1'b1; reg_sel = s;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic ard(input logic v, input logic [7:0] exp, input string tag);
    exp_t e;
    e.tag = tag; e.valid = v; e.val = exp;
    arr_q.push_back(e);
    arr_rd = 1'b1;
    @(negedge clk);
    arr_rd = 1'b0;
  endtask

  task automatic keyed_start(input logic [7:0] c);
    wr(2'd3, 8'h55);
    wr(2'd3, 8'hAA);
    wr(2'd2, c);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    chk("R1 arr_rvalid", arr_rvalid, 1'b0);
    rd(2'd2, 8'h00, "R1 ctrl after reset");
    // R9 register readback
    wr(2'd0, 8'h10);
    wr(2'd1, 8'hA5);
    rd(2'd0, 8'h10, "R9 addr read");
    rd(2'd1, 8'hA5, "R9 data read");
    rd(2'd3, 8'h00, "R9 key reads zero");
    // R2 no key
    wr(2'd2, 8'h03);
    chk("R2 start without key", busy, 1'b0);
    // R2 wrong second key
    wr(2'd3, 8'h55); wr(2'd3, 8'hAB); wr(2'd2, 8'h03);
    chk("R2 wrong key", busy, 1'b0);
    // R2 read between the key writes
    wr(2'd3, 8'h55); rd(2'd0, 8'h10, "R2 read between keys"); wr(2'd3, 8'hAA); wr(2'd2, 8'h03);
    chk("R2 access between keys", busy, 1'b0);
    // R2 read between key and start
    wr(2'd3, 8'h55); wr(2'd3, 8'hAA); rd(2'd1, 8'hA5, "R2 read before start"); wr(2'd2, 8'h03);
    chk("R2 access before start", busy, 1'b0);
    // R3 wen clear, memsel set
    keyed_start(8'h01);
    chk("R3 wen zero", busy, 1'b0);
    keyed_start(8'h07);
    chk("R3 memsel set", busy, 1'b0);
    // valid start
    keyed_start(8'h03);
    s = cyc;
    chk("R2 R4 valid start busy", busy, 1'b1);
    rd(2'd2, 8'h03, "R4 R9 ctrl busy bit");
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h77);
    ard(1'b1, 8'h00, "R8 read other location while busy");
    wr(2'd2, 8'h00);
    chk("R6 wen clear no abort", busy, 1'b1);
    keyed_start(8'h03);
    wr(2'd0, 8'h10);
    ard(1'b0, 8'h00, "R8 read busy location blocked");
    while (cyc < s + CL - 1) @(negedge clk);
    chk("R4 R6 busy through last cycle", busy, 1'b1);
    chk("R7 done clear while busy", done, 1'b0);
    @(negedge clk);
    chk("R4 busy clears", busy, 1'b0);
    chk("R7 done set at end", done, 1'b1);
    ard(1'b1, 8'hA5, "R5 latched byte stored");
    wr(2'd0, 8'h20);
    ard(1'b1, 8'h00, "R5 later addr/data not written");
    rd(2'd2, 8'h0A, "R7 R9 ctrl done and wen");
    @(negedge clk);
    chk("R7 done sticky", done, 1'b1);
    wr(2'd2, 8'h08);
    chk("R7 done cleared", done, 1'b0);
    // coincidence: clear lands on the end edge
    keyed_start(8'h03);
    s = cyc;
    chk("R4 second start", busy, 1'b1);
    while (cyc < s + CL - 1) @(negedge clk);
    wr(2'd2, 8'h0A);
    chk("R7 set wins over clear", done, 1'b1);
    chk("R4 second cycle ends", busy, 1'b0);
    ard(1'b1, 8'h77, "R5 second byte stored");
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule